// File: doc/BRIEF.md
# Multi-Word SPI Burst Engine

This engine drives the shift side of an SPI controller. A start pulse sets it running. It then pulls 32-bit words from a transmit FIFO and clocks each one out as whole bytes, with the lowest byte first. Each byte is shifted MSB first in SPI mode 0. Bytes that arrive on MISO are assembled into a 32-bit word and pushed into a receive FIFO once that word is finished.

A burst is measured in bits and set by a 12-bit configuration field. It has no fixed relation to the word size. A signed burst counter survives from one word to the next and from one start pulse to the next. It is reloaded only when it has run down to zero or below at the moment a word is taken, so a long burst can cover several words.

In multiple-burst wave mode the engine raises an exchange flag on every reload and clears it when the burst runs out, then carries straight on with the next word. Wave mode applies when the channel is a master, immediate start is off and the selected channel's wave bit is set. Outside wave mode, the end of a burst finishes the run even if words are still queued.

Top module: `spi_burst_engine`

## Requirements
- R1: The burst length in bits is the configuration field plus one. It is loaded into the counter only when the counter is zero or negative at the moment a word is popped. Otherwise the leftover count from earlier words, or from earlier runs, is used unchanged.
- R2: Wave mode is active when cfg_master_i=1, cfg_imm_i=0 and bit cfg_chan_i of cfg_wave_i is 1. In wave mode a reload sets xch_o to 1. Outside wave mode a reload leaves xch_o as it was.
- R3: Each popped word sends ceil(min(counter, 32)/8) bytes on MOSI. Bits 7:0 go first, then 15:8, and so on. Each byte reduces the counter by 8.
- R4: The received byte with index k inside a word lands in bits 8k+7:8k of rx_data_o. Bytes that were not received read as 0. One rx_push_o pulse is given per word while rx_full_i is 0.
- R5: When a word ends while rx_full_i is 1, there is no push. The word is dropped and ovf_o pulses for one cycle.
- R6: When a word ends with the counter zero or negative, xch_o is cleared. Outside wave mode, done_o then pulses and the engine goes idle, leaving any remaining words unpopped.
- R7: When the engine is ready for a new word and tx_valid_i is 0, done_o pulses, the engine goes idle and nothing is popped.
- R8: SCLK idles low and each half period lasts DIV/2 clock cycles. MOSI changes only while SCLK is low. MISO is captured at each rising SCLK edge, MSB first.
- R9: busy_o is 1 from the cycle after an accepted start until the engine returns to idle. A start pulse seen while busy is ignored, so a run gives exactly one done_o.
- R10: After reset, busy_o, sclk_o, xch_o, done_o, ovf_o, tx_pop_o and rx_push_o are all 0 and the burst counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| cfg_blen_i | input | BLEN_W | Burst length minus one, in bits |
| cfg_imm_i | input | 1 | Immediate-start setting (blocks wave mode) |
| cfg_wave_i | input | NCH | Per-channel wave-mode bits |
| cfg_chan_i | input | CH_W | Selected channel |
| cfg_master_i | input | 1 | Selected channel acts as master |
| tx_valid_i | input | 1 | Transmit FIFO holds a word |
| tx_data_i | input | WORD_W | Head word of the transmit FIFO |
| tx_pop_o | output | 1 | Take the head word |
| rx_full_i | input | 1 | Receive FIFO is full |
| rx_push_o | output | 1 | Push rx_data_o |
| rx_data_o | output | WORD_W | Assembled receive word |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Engine running |
| xch_o | output | 1 | Exchange-in-progress flag |
| done_o | output | 1 | Transfer-complete pulse |
| ovf_o | output | 1 | Receive-overflow pulse |

## Verification
The assertions assume the following about the inputs:
- tx_data_i holds the head word whenever tx_valid_i is high.
- rx_full_i reflects the FIFO and changes only after a push has been taken.
- All configuration inputs stay fixed while busy_o is high, because wave mode is evaluated again at every word end.

The stimulus keeps to these rules. Configuration and FIFO contents change only while the engine is idle, and the FIFO models apply pops and pushes on the falling edge after the cycle that requested them. A second start pulse is sent in the middle of one run to exercise the busy-ignore rule.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SHIFT_GO,
    ST_SHIFT_WAIT,
    ST_WORD_END
  } eng_state_e;

  function automatic int safe_clog2(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick_o
);
  localparam int CW = spi_burst_pkg::safe_clog2(HALF);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == CW'(HALF - 1));
  assign tick_o = en & at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!en || at_end) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
// One byte, mode 0, MSB first: rise samples MISO, fall advances MOSI.
module spi_byte_shifter #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_byte_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_byte_o,
  output logic       done_o
);
  localparam int HALF = DIV / 2;

  logic       act_q, act_d;
  logic       sclk_q, sclk_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] txs_q, txs_d;
  logic [7:0] rxs_q, rxs_d;
  logic       done_q, done_d;
  logic       tick;

  spi_half_tick #(.HALF(HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(act_q), .tick_o(tick)
  );

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    bit_d  = bit_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    done_d = 1'b0;
    if (go_i) begin
      act_d  = 1'b1;
      sclk_d = 1'b0;
      bit_d  = '0;
      txs_d  = tx_byte_i;
    end else if (tick) begin
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rxs_d  = {rxs_q[6:0], miso_i};
      end else begin
        sclk_d = 1'b0;
        if (bit_q == 3'd7) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
          txs_d = {txs_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      bit_q  <= bit_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      done_q <= done_d;
    end
  end

  assign sclk_o    = sclk_q;
  assign mosi_o    = txs_q[7];
  assign rx_byte_o = rxs_q;
  assign done_o    = done_q;
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter int DIV    = 4,
  parameter int BLEN_W = 12,
  parameter int NCH    = 4,
  parameter int WORD_W = 32,
  parameter int CH_W   = spi_burst_pkg::safe_clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BLEN_W-1:0] cfg_blen_i,
  input  logic              cfg_imm_i,
  input  logic [NCH-1:0]    cfg_wave_i,
  input  logic [CH_W-1:0]   cfg_chan_i,
  input  logic              cfg_master_i,
  input  logic              tx_valid_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              rx_full_i,
  output logic              rx_push_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              xch_o,
  output logic              done_o,
  output logic              ovf_o
);
  import spi_burst_pkg::*;

  localparam int BYTES = WORD_W / 8;
  localparam int IDX_W = safe_clog2(BYTES);
  localparam int CNT_W = BLEN_W + 2;               // signed two's complement
  localparam int BUD_W = $clog2(WORD_W) + 2;       // signed per-word budget

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  eng_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BUD_W-1:0]  bud_q, bud_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] txw_q, txw_d;
  logic [WORD_W-1:0] rxw_q, rxw_d;
  logic              xch_q, xch_d;

  logic              wave_mode, cnt_spent, bud_left;
  logic [CNT_W-1:0]  reload_val, cnt_eff, cnt_after;
  logic [BUD_W-1:0]  bud_first, bud_after;
  logic              sh_go, sh_done;
  logic [7:0]        sh_rx;

  assign wave_mode  = cfg_master_i & ~cfg_imm_i & cfg_wave_i[cfg_chan_i];
  assign cnt_spent  = cnt_q[CNT_W-1] | (cnt_q == '0);
  assign reload_val = {2'b00, cfg_blen_i} + CNT_W'(1);
  assign cnt_eff    = cnt_spent ? reload_val : cnt_q;
  assign bud_first  = (cnt_eff > CNT_W'(WORD_W)) ? BUD_W'(WORD_W) : cnt_eff[BUD_W-1:0];
  assign bud_after  = bud_q - BUD_W'(8);
  assign cnt_after  = cnt_q - CNT_W'(8);
  assign bud_left   = ~bud_after[BUD_W-1] & (bud_after != '0);
  assign sh_go      = (state_q == ST_SHIFT_GO);

  spi_byte_shifter #(.DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .go_i(sh_go), .tx_byte_i(txw_q[7:0]),
    .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .rx_byte_o(sh_rx), .done_o(sh_done)
  );

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bud_d     = bud_q;
    idx_d     = idx_q;
    txw_d     = txw_q;
    rxw_d     = rxw_q;
    xch_d     = xch_q;
    tx_pop_o  = 1'b0;
    rx_push_o = 1'b0;
    done_o    = 1'b0;
    ovf_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (!tx_valid_i) begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          tx_pop_o = 1'b1;
          txw_d    = tx_data_i;
          rxw_d    = '0;
          idx_d    = '0;
          cnt_d    = cnt_eff;
          bud_d    = bud_first;
          if (cnt_spent && wave_mode) xch_d = 1'b1;
          state_d  = ST_SHIFT_GO;
        end
      end
      ST_SHIFT_GO: state_d = ST_SHIFT_WAIT;
      ST_SHIFT_WAIT: begin
        if (sh_done) begin
          rxw_d[{idx_q, 3'b000} +: 8] = sh_rx;
          txw_d   = txw_q >> 8;
          bud_d   = bud_after;
          cnt_d   = cnt_after;
          idx_d   = idx_q + 1'b1;
          state_d = bud_left ? ST_SHIFT_GO : ST_WORD_END;
        end
      end
      ST_WORD_END: begin
        if (rx_full_i) ovf_o     = 1'b1;
        else           rx_push_o = 1'b1;
        state_d = ST_CHECK;
        if (cnt_spent) begin
          xch_d = 1'b0;
          if (!wave_mode) begin
            done_o  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bud_q   <= '0;
      idx_q   <= '0;
      txw_q   <= '0;
      rxw_q   <= '0;
      xch_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bud_q   <= bud_d;
      idx_q   <= idx_d;
      txw_q   <= txw_d;
      rxw_q   <= rxw_d;
      xch_q   <= xch_d;
    end
  end

  assign rx_data_o = rxw_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign xch_o     = xch_q;
endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid_i,
  input logic tx_pop_o,
  input logic rx_full_i,
  input logic rx_push_o,
  input logic ovf_o,
  input logic sclk_o,
  input logic busy_o,
  input logic done_o
);
  p_pop_has_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_o |-> (tx_valid_i && busy_o));

  p_push_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_o |-> !rx_full_i);

  p_push_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_o |=> !rx_push_o);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (rx_full_i && !rx_push_o));

  p_idle_sclk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o);

  p_done_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

bind spi_burst_engine spi_burst_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid_i(tx_valid_i), .tx_pop_o(tx_pop_o),
  .rx_full_i(rx_full_i), .rx_push_o(rx_push_o), .ovf_o(ovf_o),
  .sclk_o(sclk_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/spi_burst_engine_tb.sv
module spi_burst_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int RXD = 2;

  logic clk, rst_n, start_i, cfg_imm_i, cfg_master_i, tx_valid_i, rx_full_i, miso_i;
  logic [11:0] cfg_blen_i;
  logic [3:0]  cfg_wave_i;
  logic [1:0]  cfg_chan_i;
  logic [31:0] tx_data_i, rx_data_o;
  logic tx_pop_o, rx_push_o, sclk_o, mosi_o, busy_o, xch_o, done_o, ovf_o;

  spi_burst_engine #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_blen_i(cfg_blen_i),
    .cfg_imm_i(cfg_imm_i), .cfg_wave_i(cfg_wave_i), .cfg_chan_i(cfg_chan_i),
    .cfg_master_i(cfg_master_i), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_pop_o(tx_pop_o), .rx_full_i(rx_full_i), .rx_push_o(rx_push_o),
    .rx_data_o(rx_data_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .busy_o(busy_o), .xch_o(xch_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  int total = 0, bad = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [7:0]  obs_mosi[$], exp_mosi[$];
  logic [33:0] obs_ev[$], exp_ev[$];     // {is_push, xch, data}
  int obs_pops, obs_done, exp_pops, exp_left;
  int sclk_err, idle_err;
  bit pend_pop, pend_push;
  logic [31:0] pend_data;
  bit sclk_prev;
  int hi_len, mbits, s_bit, s_g;
  logic [7:0] mcur;
  // reference model state (persists across runs)
  int m_cnt = 0, m_g = 0;
  bit m_xch = 0;

  function automatic logic [7:0] gen(input int k);
    return 8'((k * 37 + 91) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // FIFO models, SPI slave, observation; every falling edge
  initial begin
    pend_pop = 0; pend_push = 0; sclk_prev = 0; hi_len = 0; mbits = 0;
    s_bit = 0; s_g = 0; mcur = '0;
    tx_valid_i = 0; tx_data_i = '0; rx_full_i = 0; miso_i = gen(0)[7];
    forever begin
      @(negedge clk);
      if (pend_pop) begin void'(txq.pop_front()); pend_pop = 0; end
      if (pend_push) begin rxq.push_back(pend_data); pend_push = 0; end
      tx_valid_i = (txq.size() > 0);
      tx_data_i  = (txq.size() > 0) ? txq[0] : '0;
      rx_full_i  = (rxq.size() >= RXD);
      #1;
      if (tx_pop_o) begin pend_pop = 1; obs_pops++; end
      if (rx_push_o) begin
        pend_push = 1; pend_data = rx_data_o;
        obs_ev.push_back({1'b1, xch_o, rx_data_o});
      end
      if (ovf_o) obs_ev.push_back({1'b0, xch_o, rx_data_o});
      if (done_o) obs_done++;
      if (!busy_o && (sclk_o || tx_pop_o || rx_push_o || ovf_o || done_o)) idle_err++;
      if (sclk_o) hi_len++;
      if (sclk_o && !sclk_prev) begin
        mcur = {mcur[6:0], mosi_o};
        mbits++;
        if (mbits == 8) begin obs_mosi.push_back(mcur); mbits = 0; end
      end
      if (!sclk_o && sclk_prev) begin
        if (hi_len != DIV / 2) sclk_err++;
        hi_len = 0;
        s_bit++;
        if (s_bit == 8) begin s_bit = 0; s_g++; end
        miso_i = gen(s_g)[7 - s_bit];
      end
      sclk_prev = sclk_o;
    end
  end

  task automatic model_run(input logic [31:0] wl[$], input int blen, input bit wave);
    logic [31:0] w, rx;
    int b, idx, rxc;
    rxc = 0; exp_pops = 0;
    exp_mosi.delete(); exp_ev.delete();
    forever begin
      if (wl.size() == 0) break;
      w = wl.pop_front(); exp_pops++;
      if (m_cnt <= 0) begin m_cnt = blen + 1; if (wave) m_xch = 1; end
      b = (m_cnt > 32) ? 32 : m_cnt; rx = '0; idx = 0;
      while (b > 0) begin
        exp_mosi.push_back(w[8*idx +: 8]);
        rx[8*idx +: 8] = gen(m_g);
        m_g++; b -= 8; m_cnt -= 8; idx++;
      end
      if (rxc >= RXD) exp_ev.push_back({1'b0, m_xch, rx});
      else begin exp_ev.push_back({1'b1, m_xch, rx}); rxc++; end
      if (m_cnt <= 0) begin m_xch = 0; if (!wave) break; end
    end
    exp_left = wl.size();
  endtask

  task automatic run(input logic [31:0] wl[$], input int blen, input bit imm,
                     input logic [3:0] wave, input logic [1:0] chan, input bit master,
                     input bit extra_start, input string tag);
    bit wm;
    int guard;
    @(posedge clk); #1;
    cfg_blen_i = 12'(blen); cfg_imm_i = imm; cfg_wave_i = wave;
    cfg_chan_i = chan; cfg_master_i = master;
    txq = wl; rxq.delete();
    obs_mosi.delete(); obs_ev.delete();
    obs_pops = 0; obs_done = 0; sclk_err = 0; idle_err = 0;
    wm = master && !imm && wave[chan];
    model_run(wl, blen, wm);
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    #2 check(busy_o === 1'b1, "R9", {tag, " busy after start"}, busy_o, 1);
    if (extra_start) begin
      repeat (20) @(negedge clk);
      start_i = 1;
      @(negedge clk); start_i = 0;
    end
    guard = 0;
    while (busy_o && guard < 20000) begin @(negedge clk); #2; guard++; end
    repeat (2) @(negedge clk);
    #2;
    check(obs_mosi.size() == exp_mosi.size(), "R3", {tag, " byte count"},
          obs_mosi.size(), exp_mosi.size());
    foreach (exp_mosi[i])
      if (i < obs_mosi.size())
        check(obs_mosi[i] == exp_mosi[i], "R3", {tag, " mosi byte"}, obs_mosi[i], exp_mosi[i]);
    check(obs_ev.size() == exp_ev.size(), "R4", {tag, " word count"},
          obs_ev.size(), exp_ev.size());
    foreach (exp_ev[i])
      if (i < obs_ev.size()) begin
        check(obs_ev[i][33] == exp_ev[i][33], "R5", {tag, " push/overflow kind"},
              obs_ev[i][33], exp_ev[i][33]);
        check(obs_ev[i][31:0] == exp_ev[i][31:0], "R4", {tag, " rx word"},
              obs_ev[i][31:0], exp_ev[i][31:0]);
        check(obs_ev[i][32] == exp_ev[i][32], "R2", {tag, " xch at word end"},
              obs_ev[i][32], exp_ev[i][32]);
      end
    check(obs_pops == exp_pops, "R1", {tag, " pops"}, obs_pops, exp_pops);
    check(txq.size() == exp_left, "R6", {tag, " words left"}, txq.size(), exp_left);
    check(obs_done == 1, "R7", {tag, " done pulses"}, obs_done, 1);
    check(xch_o == m_xch, "R6", {tag, " xch after run"}, xch_o, m_xch);
    check(sclk_err == 0, "R8", {tag, " sclk half period"}, sclk_err, 0);
    check(idle_err == 0, "R9", {tag, " activity while idle"}, idle_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; start_i = 0; cfg_blen_i = '0; cfg_imm_i = 1; cfg_wave_i = '0;
    cfg_chan_i = '0; cfg_master_i = 1;
    repeat (3) @(negedge clk);
    #2;
    check(!busy_o && !sclk_o && !xch_o && !done_o && !ovf_o && !tx_pop_o && !rx_push_o,
          "R10", "reset outputs", {busy_o, sclk_o, xch_o, done_o, ovf_o, tx_pop_o, rx_push_o}, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    // R3 R4 R9: full 32-bit burst, extra start while busy
    run('{32'hA1B2C3D4}, 31, 1, 4'h0, 2'd0, 1, 1, "s1");
    // R6: 8-bit burst stops after one word, one left
    run('{32'h11223344, 32'h55667788}, 7, 1, 4'h0, 2'd0, 1, 0, "s2");
    // R1 R6: 64-bit burst spans two words, third stays
    run('{32'h01020304, 32'hF0E0D0C0, 32'hDEAD0001}, 63, 1, 4'h0, 2'd0, 1, 0, "s3");
    // R3 R4: 12-bit burst rounds to two bytes
    run('{32'hCAFE5A3C}, 11, 1, 4'h0, 2'd0, 1, 0, "s4");
    // R2 R5 R6: wave mode, 40-bit bursts, overflow after two words
    run('{32'h10203040, 32'h50607080, 32'h90A0B0C0, 32'hD0E0F011}, 39, 0, 4'b0100, 2'd2, 1, 0, "s5");
    // R1 R2: wave mode leaves 32 bits pending with xch high
    run('{32'h77665544}, 63, 0, 4'b0100, 2'd2, 1, 0, "s6");
    // R1: leftover count used before new field is loaded
    run('{32'h13579BDF, 32'h2468ACE0}, 7, 0, 4'b0100, 2'd2, 1, 0, "s7");
    // R2: wave bit of another channel does not apply
    run('{32'hAAAA5555, 32'h0F0F0F0F}, 7, 0, 4'b0100, 2'd1, 1, 0, "s8");
    // R2: non-master does not enter wave mode
    run('{32'h3C3C3C3C, 32'hC3C3C3C3}, 7, 0, 4'b1111, 2'd0, 0, 0, "s9");
    // R7: start with empty FIFO
    run('{}, 15, 1, 4'h0, 2'd0, 1, 0, "s10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule